// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Detector

This block watches four asynchronous input pins and turns transitions on them into sticky interrupt request flags. Each channel has a 2-bit edge mode that picks falling-edge, rising-edge or both-edge detection, or switches the channel off. A separate per-pin enable decides whether the shared pin is used as an interrupt source at all. A channel is active only when its mode is non-zero and its enable bit is set.

Each pin first goes through a two-flop synchronizer. Edges are then found by comparing the synchronized level with the level held at the previous machine-cycle enable (`mc_en`), so a flag can only be set on a clock where `mc_en` is high. A flag stays set until one of two things clears it: a one-cycle acknowledge pulse on that channel, or a register write of 0 to its bit. While a channel is inactive, its history follows the pin, so enabling a channel or changing its mode never produces a false edge.

Software uses a single-cycle register port. A write is taken on any clock where `reg_wr` is high, and no handshake is involved. The read data is combinational from `reg_addr`. No data stream crosses the block boundary, so there is no valid/ready interface and no back-pressure.

Top module: `ext_irq_edge_top`

## Requirements
- R1: After reset, the edge-mode, pin-enable and flag registers all read 0, and `irq_req` is 0.
- R2: Register addresses are as follows. Address 0 is edge mode, with channel n in bits 2n+1:2n. Address 1 is pin enable, with channel n in bit n and bits 7:4 reading 0. Address 2 is the flag register, with channel n in bit n. Address 3 reads 0. A write takes effect at the clock edge where `reg_wr` is high.
- R3: Mode code 01 sets the channel flag on a falling edge only.
- R4: Mode code 10 sets the channel flag on a rising edge only.
- R5: Mode code 11 sets the channel flag on both rising and falling edges.
- R6: Mode code 00 disables the channel, and pin transitions do not set its flag.
- R7: A channel whose pin-enable bit is 0 never sets its flag.
- R8: Flags are set only on clocks where `mc_en` is high. With `mc_en` held high, a pin change driven before clock edge 1 appears on `irq_req` after clock edge 3, and not after edge 2.
- R9: A set flag stays set until a one-cycle `irq_ack` pulse on that channel clears it. Other channels are unaffected.
- R10: Writing the flag register clears each flag whose written bit is 0. A written 1 leaves the flag unchanged and never sets it.
- R11: When a new edge is detected in the same cycle as a clear, the flag ends up set.
- R12: Setting a channel's enable bit, or changing its mode from 00, while the pin sits at a steady level does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | Machine-cycle enable that qualifies edge latching |
| irq_pin | input | 4 | Asynchronous external interrupt pins |
| irq_ack | input | 4 | Per-channel flag clear pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq_req | output | 4 | Sticky interrupt request flags |

## Verification
Every mode code is driven with both rising and falling pin steps, and several channels are set to different modes at once. This shows that each 2-bit field reaches the correct channel and that each code reacts to exactly its own edge polarity. Steps applied while `mc_en` is low, and steps sampled one edge before and at the expected latency, separate correct enable gating from an extra or missing pipeline stage. Enabling channels against a pin held high, and a clear timed on the very cycle an edge is detected, separate correct history reloading and set-over-clear priority from designs that glitch or lose edges.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int MODE_W = 2;
  localparam int ADDR_W = 2;

  typedef enum logic [MODE_W-1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_t;

  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PSEL = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic              pin,
  input  logic [MODE_W-1:0] mode,
  input  logic              pin_sel,
  input  logic              clr,
  output logic              flag
);
  logic       lvl;
  logic       hist_q;
  logic       active;
  logic       rise;
  logic       fall;
  logic       hit;
  edge_mode_t mode_e;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin),
    .q    (lvl)
  );

  assign mode_e = edge_mode_t'(mode);
  assign active = pin_sel && (mode_e != EDGE_OFF);

  // While inactive, history follows the pin so enabling never sees a stale level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hist_q <= 1'b0;
    else if (!active || mc_en) hist_q <= lvl;
  end

  assign rise = lvl & ~hist_q;
  assign fall = ~lvl & hist_q;

  always_comb begin
    hit = 1'b0;
    if (active && mc_en) begin
      case (mode_e)
        EDGE_FALL: hit = fall;
        EDGE_RISE: hit = rise;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end

  // A fresh edge has priority over any clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int ESEL_W = NUM_CH * MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NUM_CH-1:0] flags,
  output logic [ESEL_W-1:0] esel_q,
  output logic [NUM_CH-1:0] psel_q,
  output logic [NUM_CH-1:0] sw_clr,
  output logic [DATA_W-1:0] rdata
);
  logic wr_mode;
  logic wr_psel;
  logic wr_flag;

  assign wr_mode = wr && (addr == ADDR_MODE);
  assign wr_psel = wr && (addr == ADDR_PSEL);
  assign wr_flag = wr && (addr == ADDR_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       esel_q <= '0;
    else if (wr_mode) esel_q <= wdata[ESEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       psel_q <= '0;
    else if (wr_psel) psel_q <= wdata[NUM_CH-1:0];
  end

  // Zero bits in a flag write clear; ones leave the flag alone.
  assign sw_clr = wr_flag ? ~wdata[NUM_CH-1:0] : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_MODE: rdata[ESEL_W-1:0] = esel_q;
      ADDR_PSEL: rdata[NUM_CH-1:0] = psel_q;
      ADDR_FLAG: rdata[NUM_CH-1:0] = flags;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/ext_irq_edge_top.sv
module ext_irq_edge_top
  import ext_irq_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic [3:0]        irq_pin,
  input  logic [3:0]        irq_ack,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [3:0]        irq_req
);
  localparam int ESEL_W = NUM_CH * MODE_W;

  logic [ESEL_W-1:0] esel_q;
  logic [NUM_CH-1:0] psel_q;
  logic [NUM_CH-1:0] sw_clr;
  logic [NUM_CH-1:0] flags;

  ext_irq_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .flags (flags),
    .esel_q(esel_q),
    .psel_q(psel_q),
    .sw_clr(sw_clr),
    .rdata (reg_rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ext_irq_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .mc_en  (mc_en),
      .pin    (irq_pin[g]),
      .mode   (esel_q[g*MODE_W +: MODE_W]),
      .pin_sel(psel_q[g]),
      .clr    (irq_ack[g] | sw_clr[g]),
      .flag   (flags[g])
    );
  end

  assign irq_req = flags;
endmodule

// File: rtl/ext_irq_edge_chk.sv
module ext_irq_edge_chk #(
  parameter int NUM_CH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mc_en,
  input logic [NUM_CH-1:0]   irq_ack,
  input logic                reg_wr,
  input logic [1:0]          reg_addr,
  input logic [7:0]          reg_wdata,
  input logic [2*NUM_CH-1:0] esel_q,
  input logic [NUM_CH-1:0]   psel_q,
  input logic [NUM_CH-1:0]   irq_req
);
  // R1: while reset is held, everything is cleared by the following edge
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (irq_req == '0 && esel_q == '0 && psel_q == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_prop
    // R8: a flag can only rise on an enabled machine cycle
    p_set_on_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[g]) |-> $past(mc_en));
    // R7: a deselected pin never raises its flag
    p_set_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[g]) |-> $past(psel_q[g]));
    // R6: mode 00 never raises the flag
    p_set_needs_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req[g]) |-> ($past(esel_q[2*g +: 2]) != 2'b00));
    // R9: with no clear request, a set flag holds
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[g] && !irq_ack[g] && !(reg_wr && reg_addr == 2'd2 && !reg_wdata[g]))
        |=> irq_req[g]);
    // R9: an acknowledge with no possible new edge clears the flag
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req[g] && irq_ack[g] && !mc_en) |=> !irq_req[g]);
  end
endmodule

bind ext_irq_edge_top ext_irq_edge_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mc_en    (mc_en),
  .irq_ack  (irq_ack),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .esel_q   (esel_q),
  .psel_q   (psel_q),
  .irq_req  (irq_req)
);

// File: tb/ext_irq_edge_top_tb.sv
`timescale 1ns/1ps
module ext_irq_edge_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_en = 1'b1;
  logic [3:0] irq_pin = 4'h0;
  logic [3:0] irq_ack = 4'h0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [3:0] irq_req;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_edge_top u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_en    (mc_en),
    .irq_pin  (irq_pin),
    .irq_ack  (irq_ack),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq_req  (irq_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    cyc(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic idle();
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd1, 8'h00);
    irq_pin = 4'h0;
    mc_en = 1'b1;
    cyc(4);
    irq_ack = 4'hF; cyc(1); irq_ack = 4'h0;
    cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 req", {4'h0, irq_req}, 8'h00);
    rd_chk("R1 mode", 2'd0, 8'h00);
    rd_chk("R1 psel", 2'd1, 8'h00);
    rd_chk("R1 flag", 2'd2, 8'h00);
  endtask

  task automatic t_regs();
    wr_reg(2'd0, 8'hB4);
    rd_chk("R2 mode readback", 2'd0, 8'hB4);
    wr_reg(2'd1, 8'hFA);
    rd_chk("R2 psel upper zero", 2'd1, 8'h0A);
    rd_chk("R2 addr3 zero", 2'd3, 8'h00);
    idle();
  endtask

  task automatic t_fall();
    irq_pin = 4'hF; cyc(4);
    wr_reg(2'd0, 8'h11);          // falling on ch0 and ch2
    wr_reg(2'd1, 8'h05);
    cyc(4);
    chk("R12 enable at high level", {4'h0, irq_req}, 8'h00);
    irq_pin = 4'b1010; cyc(4);
    chk("R3 falling sets ch0 ch2", {4'h0, irq_req}, 8'h05);
    irq_ack = 4'hF; cyc(1); irq_ack = 4'h0;
    irq_pin = 4'hF; cyc(4);
    chk("R3 rising ignored", {4'h0, irq_req}, 8'h00);
    idle();
  endtask

  task automatic t_rise();
    wr_reg(2'd0, 8'hAA);
    wr_reg(2'd1, 8'h0F);
    irq_pin = 4'b0011; cyc(4);
    chk("R4 rising sets", {4'h0, irq_req}, 8'h03);
    irq_ack = 4'hF; cyc(1); irq_ack = 4'h0;
    irq_pin = 4'b0000; cyc(4);
    chk("R4 falling ignored", {4'h0, irq_req}, 8'h00);
    idle();
  endtask

  task automatic t_both();
    wr_reg(2'd0, 8'hFF);
    wr_reg(2'd1, 8'h0F);
    irq_pin = 4'b0101; cyc(4);
    chk("R5 rise", {4'h0, irq_req}, 8'h05);
    irq_ack = 4'hF; cyc(1); irq_ack = 4'h0;
    irq_pin = 4'b0000; cyc(4);
    chk("R5 fall", {4'h0, irq_req}, 8'h05);
    idle();
  endtask

  task automatic t_off();
    wr_reg(2'd0, 8'hA2);          // ch1 mode 00, others rising
    wr_reg(2'd1, 8'h0F);
    irq_pin = 4'hF; cyc(4);
    chk("R6 off channel quiet", {4'h0, irq_req}, 8'h0D);
    rd_chk("R6 flag readback", 2'd2, 8'h0D);
    idle();
  endtask

  task automatic t_psel();
    wr_reg(2'd0, 8'hAA);
    wr_reg(2'd1, 8'h06);
    irq_pin = 4'hF; cyc(4);
    chk("R7 deselected quiet", {4'h0, irq_req}, 8'h06);
    idle();
  endtask

  task automatic t_enable();
    wr_reg(2'd0, 8'hAA);
    wr_reg(2'd1, 8'h0F);
    mc_en = 1'b0;
    irq_pin = 4'b0001; cyc(6);
    chk("R8 no set without enable", {4'h0, irq_req}, 8'h00);
    mc_en = 1'b1; cyc(1); mc_en = 1'b0;
    chk("R8 set on enable", {4'h0, irq_req}, 8'h01);
    mc_en = 1'b1;
    irq_pin = 4'b0011; cyc(2);
    chk("R8 not after edge 2", {4'h0, irq_req}, 8'h01);
    cyc(1);
    chk("R8 after edge 3", {4'h0, irq_req}, 8'h03);
    idle();
  endtask

  task automatic t_ack();
    wr_reg(2'd0, 8'hAA);
    wr_reg(2'd1, 8'h0F);
    irq_pin = 4'b0111; cyc(4);
    cyc(10);
    chk("R9 sticky", {4'h0, irq_req}, 8'h07);
    irq_ack = 4'b0001; cyc(1); irq_ack = 4'h0;
    chk("R9 ack clears one", {4'h0, irq_req}, 8'h06);
    idle();
  endtask

  task automatic t_swclr();
    wr_reg(2'd0, 8'hAA);
    wr_reg(2'd1, 8'h0F);
    irq_pin = 4'b0011; cyc(4);
    wr_reg(2'd2, 8'hFE);
    chk("R10 zero clears", {4'h0, irq_req}, 8'h02);
    wr_reg(2'd2, 8'hFF);
    chk("R10 one no set", {4'h0, irq_req}, 8'h02);
    idle();
  endtask

  task automatic t_collide();
    wr_reg(2'd0, 8'h03);          // ch0 both edges
    wr_reg(2'd1, 8'h01);
    irq_pin = 4'b0001; cyc(4);
    chk("R11 pre set", {4'h0, irq_req}, 8'h01);
    irq_pin = 4'b0000;
    cyc(2);
    irq_ack = 4'b0001; cyc(1); irq_ack = 4'h0;
    chk("R11 edge beats ack", {4'h0, irq_req}, 8'h01);
    irq_ack = 4'b0001; cyc(1); irq_ack = 4'h0;
    chk("R11 later ack clears", {4'h0, irq_req}, 8'h00);
    idle();
  endtask

  task automatic t_nofalse();
    wr_reg(2'd0, 8'hAA);
    irq_pin = 4'hF; cyc(4);
    wr_reg(2'd1, 8'h0F);
    cyc(4);
    chk("R12 select while high", {4'h0, irq_req}, 8'h00);
    wr_reg(2'd0, 8'h00);
    irq_pin = 4'h0; cyc(4);
    wr_reg(2'd0, 8'h55);
    cyc(4);
    chk("R12 mode change while low", {4'h0, irq_req}, 8'h00);
    idle();
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_regs();
    t_fall();
    t_rise();
    t_both();
    t_off();
    t_psel();
    t_enable();
    t_ack();
    t_swclr();
    t_collide();
    t_nofalse();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule